// File: doc/BRIEF.md
# DSP Address Generator

This block turns an access request from a signal-processing load/store path into a memory address. In the same evaluation it produces the pointer value that the register file should hold after the access. The register file and the memory sit outside the block. A mode code selects how the address is formed. The block also receives the current base or pointer register, an index register, a signed 16-bit immediate, a row-size shift, a step value, and the bounds of a circular buffer. All arithmetic is unsigned and 32 bits wide, and it wraps modulo 2^32 unless a requirement states otherwise.

The block is purely combinational and has no states or transitions. The address, the updated pointer and the write-back enable all settle from the current inputs. Two modes update their pointer on their own: circular and strided. Both use the pointer itself as the access address (post-modify). In every other mode the write-back enable is low and the updated pointer simply repeats the base input.

Top module: `dsp_agu`

## Requirements
- R1: Mode code 0 (displacement) gives an address equal to base plus the 16-bit immediate, sign-extended from bit 15. An immediate of zero gives register-indirect access.
- R2: Mode code 1 (indexed) gives an address equal to base plus index.
- R3: Mode code 2 (scaled) gives an address equal to base plus index shifted left by the 3-bit row shift (0 to 7).
- R4: Mode code 3 (circular) gives an address equal to the pointer (base input) and raises write-back. When pointer plus step is below start plus length, the updated pointer is pointer plus step.
- R5: In circular mode, when pointer plus step is greater than or equal to start plus length (compared without 32-bit truncation), the updated pointer is start plus the amount by which the sum reaches past start plus length. An exact hit on the end gives start.
- R6: Mode code 4 (bit-reverse) reverses the low n bits of base, with n equal to the 4-bit field value plus one (1 to 16). The bits above n are unchanged, and write-back is low.
- R7: Mode code 5 (strided) gives an address equal to the pointer, an updated pointer equal to pointer plus step, and write-back high.
- R8: Mode codes 6 and 7 are reserved. They give address equal to base, updated pointer equal to base, and write-back low.
- R9: In every mode other than circular and strided, write-back is low and the updated pointer equals base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 3 | Addressing mode code |
| base_i | input | 32 | Base register or current pointer |
| index_i | input | 32 | Index register |
| imm_i | input | 16 | Signed immediate offset |
| row_shift_i | input | 3 | Log2 of the row size for scaled mode |
| step_i | input | 32 | Pointer increment for circular and strided modes |
| buf_start_i | input | 32 | First address of the circular buffer |
| buf_len_i | input | 32 | Length of the circular buffer |
| brev_sel_i | input | 4 | Bit-reverse width minus one |
| ea_o | output | 32 | Effective address |
| ptr_next_o | output | 32 | Pointer value to write back |
| wb_en_o | output | 1 | Write-back enable |

## Verification
In circular mode, the access at the old pointer and the wraparound of the updated pointer happen in the same evaluation. The bench provokes this by placing a 12-entry buffer and sweeping every pointer inside it against every step from 1 to 12, so each pointer reaches the end, lands exactly on it, or passes it. Each case is judged on both the address, which must stay at the old pointer, and the updated pointer, which the bench computes in 64-bit arithmetic. A buffer ending exactly at 2^32 checks that the end comparison does not truncate.

// File: rtl/dsp_agu_pkg.sv
package dsp_agu_pkg;

    localparam int AGU_AW    = 32;
    localparam int AGU_IW    = 16;
    localparam int AGU_SW    = 3;
    localparam int AGU_RMAX  = 16;
    localparam int AGU_NW    = 4;

    typedef enum logic [2:0] {
        AM_DISP   = 3'd0,
        AM_INDEX  = 3'd1,
        AM_SCALED = 3'd2,
        AM_CIRC   = 3'd3,
        AM_BITREV = 3'd4,
        AM_STRIDE = 3'd5,
        AM_RSV6   = 3'd6,
        AM_RSV7   = 3'd7
    } agu_mode_e;

endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
    parameter int AW = 32,
    parameter int IW = 16,
    parameter int SW = 3
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] index_i,
    input  logic [IW-1:0] imm_i,
    input  logic [SW-1:0] shift_i,
    output logic [AW-1:0] disp_ea_o,
    output logic [AW-1:0] idx_ea_o,
    output logic [AW-1:0] scl_ea_o
);

    logic [AW-1:0] imm_ext;
    logic [AW-1:0] idx_scaled;

    always_comb begin
        imm_ext    = {{(AW-IW){imm_i[IW-1]}}, imm_i};
        idx_scaled = index_i << shift_i;
        disp_ea_o  = base_i + imm_ext;
        idx_ea_o   = base_i + index_i;
        scl_ea_o   = base_i + idx_scaled;
    end

    // R3: a row shift of zero must reduce scaled mode to plain indexed mode
    always_comb begin
        if (shift_i == '0) begin
            assert_scale_unity_R3: assert (scl_ea_o == idx_ea_o);
        end
    end

endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] step_i,
    input  logic [AW-1:0] start_i,
    input  logic [AW-1:0] len_i,
    output logic [AW-1:0] next_o
);

    logic [AW:0] sum_w;
    logic [AW:0] end_w;
    logic [AW:0] over_w;
    logic        wrap;

    always_comb begin
        sum_w  = {1'b0, ptr_i} + {1'b0, step_i};
        end_w  = {1'b0, start_i} + {1'b0, len_i};
        over_w = sum_w - end_w;
        wrap   = (sum_w >= end_w);
        if (wrap) begin
            next_o = start_i + over_w[AW-1:0];
        end else begin
            next_o = sum_w[AW-1:0];
        end
    end

    // R5: a pointer inside the buffer with a step no larger than the buffer stays inside
    always_comb begin
        if ((ptr_i >= start_i) && ((ptr_i - start_i) < len_i) &&
            (step_i <= len_i) && !end_w[AW]) begin
            assert_stay_in_buffer_R5: assert ((next_o - start_i) < len_i);
        end
    end

endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
    parameter int AW   = 32,
    parameter int RMAX = 16,
    parameter int NW   = 4
) (
    input  logic [AW-1:0] addr_i,
    input  logic [NW-1:0] nsel_i,
    output logic [AW-1:0] ea_o
);

    localparam int CW = $clog2(RMAX) + 1;

    logic [RMAX-1:0] rev_full;
    logic [RMAX-1:0] rev_low;
    logic [RMAX-1:0] low_mask;
    logic [AW-1:0]   mask_full;
    logic [CW-1:0]   nbits;
    logic [CW-1:0]   shamt;

    for (genvar gi = 0; gi < RMAX; gi++) begin : g_rev
        assign rev_full[gi] = addr_i[RMAX-1-gi];
    end

    always_comb begin
        nbits     = CW'(nsel_i) + CW'(1);
        shamt     = CW'(RMAX) - nbits;
        rev_low   = rev_full >> shamt;
        low_mask  = {RMAX{1'b1}} >> shamt;
        mask_full = {{(AW-RMAX){1'b0}}, low_mask};
        ea_o      = (addr_i & ~mask_full) | {{(AW-RMAX){1'b0}}, rev_low};
    end

    // R6: reversal permutes the low bits, so their population count is kept
    always_comb begin
        assert_popcount_kept_R6: assert ($countones(ea_o & mask_full) ==
                                         $countones(addr_i & mask_full));
    end

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
    import dsp_agu_pkg::*;
#(
    parameter int AW   = AGU_AW,
    parameter int IW   = AGU_IW,
    parameter int SW   = AGU_SW,
    parameter int RMAX = AGU_RMAX,
    parameter int NW   = AGU_NW
) (
    input  logic [2:0]    mode_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] index_i,
    input  logic [IW-1:0] imm_i,
    input  logic [SW-1:0] row_shift_i,
    input  logic [AW-1:0] step_i,
    input  logic [AW-1:0] buf_start_i,
    input  logic [AW-1:0] buf_len_i,
    input  logic [NW-1:0] brev_sel_i,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] ptr_next_o,
    output logic          wb_en_o
);

    agu_mode_e     mode;
    logic [AW-1:0] disp_ea;
    logic [AW-1:0] idx_ea;
    logic [AW-1:0] scl_ea;
    logic [AW-1:0] circ_next;
    logic [AW-1:0] brev_ea;
    logic [AW-1:0] stride_next;

    assign mode        = agu_mode_e'(mode_i);
    assign stride_next = base_i + step_i;

    agu_offset #(.AW(AW), .IW(IW), .SW(SW)) u_offset (
        .base_i    (base_i),
        .index_i   (index_i),
        .imm_i     (imm_i),
        .shift_i   (row_shift_i),
        .disp_ea_o (disp_ea),
        .idx_ea_o  (idx_ea),
        .scl_ea_o  (scl_ea)
    );

    agu_circ #(.AW(AW)) u_circ (
        .ptr_i   (base_i),
        .step_i  (step_i),
        .start_i (buf_start_i),
        .len_i   (buf_len_i),
        .next_o  (circ_next)
    );

    agu_bitrev #(.AW(AW), .RMAX(RMAX), .NW(NW)) u_bitrev (
        .addr_i (base_i),
        .nsel_i (brev_sel_i),
        .ea_o   (brev_ea)
    );

    always_comb begin
        ea_o       = base_i;
        ptr_next_o = base_i;
        wb_en_o    = 1'b0;
        unique case (mode)
            AM_DISP:   ea_o = disp_ea;
            AM_INDEX:  ea_o = idx_ea;
            AM_SCALED: ea_o = scl_ea;
            AM_CIRC: begin
                ptr_next_o = circ_next;
                wb_en_o    = 1'b1;
            end
            AM_BITREV: ea_o = brev_ea;
            AM_STRIDE: begin
                ptr_next_o = stride_next;
                wb_en_o    = 1'b1;
            end
            AM_RSV6, AM_RSV7: ;
        endcase
    end

    // R4 / R7: post-modify modes access at the unmodified pointer
    always_comb begin
        if (wb_en_o) begin
            assert_postmod_addr_R7: assert (ea_o == base_i);
        end
    end

    // R9: without write-back the pointer output repeats the base
    always_comb begin
        if (!wb_en_o) begin
            assert_hold_pointer_R9: assert (ptr_next_o == base_i);
        end
    end

endmodule

// File: tb/dsp_agu_tb.sv
module dsp_agu_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [2:0]  mode_i;
    logic [31:0] base_i, index_i, step_i, buf_start_i, buf_len_i;
    logic [15:0] imm_i;
    logic [2:0]  row_shift_i;
    logic [3:0]  brev_sel_i;
    logic [31:0] ea_o, ptr_next_o;
    logic        wb_en_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsp_agu u_dut (
        .mode_i      (mode_i),
        .base_i      (base_i),
        .index_i     (index_i),
        .imm_i       (imm_i),
        .row_shift_i (row_shift_i),
        .step_i      (step_i),
        .buf_start_i (buf_start_i),
        .buf_len_i   (buf_len_i),
        .brev_sel_i  (brev_sel_i),
        .ea_o        (ea_o),
        .ptr_next_o  (ptr_next_o),
        .wb_en_o     (wb_en_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] m, input logic [31:0] b);
        @(negedge clk);
        mode_i = m;
        base_i = b;
        #(CLK_PERIOD/4);
    endtask

    function automatic logic [31:0] ref_brev(input logic [31:0] a, input int n);
        logic [31:0] r = a;
        for (int i = 0; i < n; i++) r[i] = a[n-1-i];
        return r;
    endfunction

    function automatic logic [31:0] ref_circ(input logic [31:0] p, input logic [31:0] s,
                                             input logic [31:0] st, input logic [31:0] ln);
        longint unsigned sum = longint'(p) + longint'(s);
        longint unsigned en  = longint'(st) + longint'(ln);
        if (sum >= en) return 32'(longint'(st) + (sum - en));
        return 32'(sum);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] imm_set [6];
        logic [31:0] b_set [4];
        mode_i = 3'd0; base_i = '0; index_i = '0; imm_i = '0; row_shift_i = '0;
        step_i = '0; buf_start_i = '0; buf_len_i = '0; brev_sel_i = '0;

        // Idle state with all inputs zero (R1, R9)
        apply(3'd0, 32'h0);
        check("R1", "idle ea", ea_o, 32'h0);
        check("R9", "idle next", ptr_next_o, 32'h0);
        check("R9", "idle wb", {31'b0, wb_en_o}, 32'h0);

        // R1 displacement with sign extension
        imm_set = '{32'h0000, 32'h0001, 32'h7FFF, 32'h8000, 32'hFFFF, 32'h1234};
        foreach (imm_set[k]) begin
            imm_i = imm_set[k][15:0];
            apply(3'd0, 32'h0001_0000);
            check("R1", "disp ea", ea_o,
                  32'h0001_0000 + {{16{imm_set[k][15]}}, imm_set[k][15:0]});
            check("R9", "disp wb", {31'b0, wb_en_o}, 32'h0);
        end
        imm_i = 16'hFFFF;
        apply(3'd0, 32'h0);
        check("R1", "disp wrap ea", ea_o, 32'hFFFF_FFFF);

        // R2 indexed
        for (int k = 0; k < 8; k++) begin
            index_i = 32'h1111_0000 * k + 32'd7;
            apply(3'd1, 32'hF000_0000);
            check("R2", "index ea", ea_o, 32'hF000_0000 + index_i);
            check("R9", "index next", ptr_next_o, 32'hF000_0000);
        end

        // R3 scaled, every row shift
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 4; k++) begin
                row_shift_i = 3'(s);
                index_i     = 32'd5 + 32'(k) * 32'h0100_0003;
                apply(3'd2, 32'h0000_4000);
                check("R3", "scaled ea", ea_o, 32'h0000_4000 + (index_i << s));
            end
        end

        // R4 / R5 circular: every pointer in a 12-entry buffer against every step
        buf_start_i = 32'h0000_0100;
        buf_len_i   = 32'd12;
        for (int p = 0; p < 12; p++) begin
            for (int s = 1; s <= 12; s++) begin
                step_i = 32'(s);
                apply(3'd3, 32'h100 + 32'(p));
                check("R4", "circ ea", ea_o, 32'h100 + 32'(p));
                check("R4", "circ wb", {31'b0, wb_en_o}, 32'h1);
                check((p + s >= 12) ? "R5" : "R4", "circ next", ptr_next_o,
                      ref_circ(32'h100 + 32'(p), step_i, buf_start_i, buf_len_i));
            end
        end
        // R5 exact end hit lands on start
        step_i = 32'd1;
        apply(3'd3, 32'h10B);
        check("R5", "circ exact end", ptr_next_o, 32'h100);
        // R5 buffer ending at 2^32: comparison must not truncate
        buf_start_i = 32'hFFFF_FFF0;
        buf_len_i   = 32'd16;
        step_i      = 32'd3;
        apply(3'd3, 32'hFFFF_FFFE);
        check("R5", "circ top wrap", ptr_next_o, 32'hFFFF_FFF1);
        step_i = 32'd1;
        apply(3'd3, 32'hFFFF_FFF5);
        check("R4", "circ top nowrap", ptr_next_o, 32'hFFFF_FFF6);

        // R6 bit reverse, every width
        b_set = '{32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0001, 32'hFFFF_8000};
        foreach (b_set[k]) begin
            for (int n = 1; n <= 16; n++) begin
                brev_sel_i = 4'(n - 1);
                apply(3'd4, b_set[k]);
                check("R6", "brev ea", ea_o, ref_brev(b_set[k], n));
                check("R6", "brev wb", {31'b0, wb_en_o}, 32'h0);
            end
        end

        // R7 strided
        for (int k = 0; k < 6; k++) begin
            step_i = 32'h40 * 32'(k) + 32'hFFFF_FFF0 * 32'(k % 2);
            apply(3'd5, 32'h8000_0000 + 32'(k));
            check("R7", "stride ea", ea_o, 32'h8000_0000 + 32'(k));
            check("R7", "stride next", ptr_next_o, 32'h8000_0000 + 32'(k) + step_i);
            check("R7", "stride wb", {31'b0, wb_en_o}, 32'h1);
        end

        // R8 reserved codes
        for (int m = 6; m < 8; m++) begin
            index_i = 32'h55; imm_i = 16'h10; step_i = 32'h4;
            apply(3'(m), 32'hABCD_0123);
            check("R8", "rsv ea", ea_o, 32'hABCD_0123);
            check("R8", "rsv next", ptr_next_o, 32'hABCD_0123);
            check("R8", "rsv wb", {31'b0, wb_en_o}, 32'h0);
        end

        // R9 non-updating modes hold the pointer even with a step present
        step_i = 32'h99;
        for (int m = 0; m < 5; m++) begin
            if (m != 3) begin
                apply(3'(m), 32'h0000_7777);
                check("R9", "hold next", ptr_next_o, 32'h0000_7777);
                check("R9", "hold wb", {31'b0, wb_en_o}, 32'h0);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule